// File: doc/BRIEF.md
# Built-In-Test Self-Check Sequencer and Result Classifier

This block runs one self-checking measurement cycle for a built-in-test channel. On a start pulse it walks through four timed phases. It first applies no stimulus. It then applies a scaled-down copy of the signal that must read healthy, then a noise-loaded copy that must read faulty, and finally the live system signal. A stimulus select output tells the analog front end which of the four to route to the window comparator. The block does no scaling, noise injection or threshold generation itself.

On the last cycle of each phase the block records the comparator outcome as one 2-bit symbol. The outcome is pass, fault (the value lies outside the lower/upper window), or error code (the channel flagged corrupt data). The four symbols form a result vector. After the live phase the vector is sorted into a verdict. The verdict separates a healthy or faulty monitored system, seen through a trustworthy test path, from a failed test path, an ambiguous case, a pattern that cannot occur, and anything else. A one-cycle done pulse marks a new verdict. The verdict and the vector then hold until the next start.

States: `ST_IDLE` (waiting), `ST_QUIET` (no stimulus), `ST_GOOD` (healthy stimulus), `ST_BAD` (fault stimulus), `ST_LIVE` (live signal), `ST_JUDGE` (classify). Transitions: IDLE→QUIET on start; QUIET→GOOD, GOOD→BAD and BAD→LIVE when the phase counter reaches its last cycle; LIVE→JUDGE on the last cycle of the live phase; JUDGE→IDLE unconditionally after one cycle.

Top module: `bit_selfcheck`

## Requirements
- R1: `stim_sel_o` is 0 (no stimulus) when idle and during the quiet phase, 1 in the healthy-stimulus phase, 2 in the fault-stimulus phase and 3 in the live phase. The phases always run in that order.
- R2: Each phase lasts L clock cycles, where L is `phase_len_i` captured on the accepted start. A value of 0 is treated as 1. The comparator inputs are sampled on the last cycle of each phase.
- R3: Each phase symbol is 00 for pass, 01 for fault and 10 for error code; the error flag wins over the fault flag, and 11 is never produced. `result_vec_o[1:0]` holds the quiet phase, `[3:2]` the healthy phase, `[5:4]` the fault phase and `[7:6]` the live phase.
- R4: Written in phase order, pattern [0,0,1,0] gives verdict 1 (system healthy, test path healthy) and [0,0,1,1] gives verdict 2 (system faulty, test path healthy).
- R5: Patterns [0,0,0,0], [R,R,R,R] and [0,1,1,1] give verdict 3 (test path failed, system state unknown, offline test needed).
- R6: Pattern [0,R,R,R] gives verdict 4 (ambiguous test-path or system fault). Pattern [0,0,0,1] gives verdict 5 (impossible result).
- R7: Every other pattern gives verdict 6 (unclassified, test path suspect).
- R8: `done_o` is high for exactly one cycle, 4·L+1 clock edges after the edge that accepts start. The new verdict appears in that same cycle.
- R9: A start pulse that arrives while a cycle is running has no effect on timing, vector or verdict, and produces no extra done pulse.
- R10: An accepted start clears the vector to 0 and the verdict to 0 (none). After done, vector and verdict hold unchanged until the next accepted start.
- R11: After reset `stim_sel_o`, `result_vec_o`, `verdict_o` and `done_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one self-check cycle |
| phase_len_i | input | LEN_W | Cycles per phase, captured on start (0 acts as 1) |
| cmp_fail_i | input | 1 | Window comparator: feature outside the bounds |
| cmp_err_i | input | 1 | Channel reports an error code |
| stim_sel_o | output | 2 | Stimulus select: 0 none, 1 healthy, 2 fault, 3 live |
| result_vec_o | output | 8 | Four captured 2-bit phase symbols |
| verdict_o | output | 3 | Classification code 0..6 |
| done_o | output | 1 | One-cycle pulse when a verdict is ready |

## Verification
On every cycle the assertions check the following. The phases advance only in their fixed order and only on the last counted cycle. A start during a run never restarts the sequence. The error flag takes priority when a symbol is captured. The done pulse never lasts two cycles. The verdict changes only on start or judgement. They also check the verdict codes for the healthy pattern and the impossible pattern. Only the bench scenarios show the following. They show the exact cycle count from start to done for several phase lengths, including the length-0 corner. They show that the full classification map holds over every listed pattern and some unlisted ones. They also show that an ignored mid-run start leaves the scored result intact.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    localparam int NPH   = 4;
    localparam int SYM_W = 2;
    localparam int VEC_W = NPH * SYM_W;
    localparam int PH_W  = $clog2(NPH);
    localparam int CLS_W = 3;

    typedef enum logic [SYM_W-1:0] {
        SYM_PASS = 2'b00,
        SYM_FAIL = 2'b01,
        SYM_ERR  = 2'b10,
        SYM_RSV  = 2'b11
    } sym_e;

    typedef enum logic [CLS_W-1:0] {
        CL_NONE      = 3'd0,
        CL_ALL_OK    = 3'd1,
        CL_SYS_FAULT = 3'd2,
        CL_BIT_FAIL  = 3'd3,
        CL_AMBIG     = 3'd4,
        CL_IMPOSS    = 3'd5,
        CL_UNKNOWN   = 3'd6
    } class_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUIET,
        ST_GOOD,
        ST_BAD,
        ST_LIVE,
        ST_JUDGE
    } state_e;

    function automatic logic [VEC_W-1:0] pack4(sym_e p0, sym_e p1, sym_e p2, sym_e p3);
        return {p3, p2, p1, p0};
    endfunction
endpackage

// File: rtl/bsc_phase_ctrl.sv
module bsc_phase_ctrl
    import bsc_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [LEN_W-1:0]    len_i,
    output logic [PH_W-1:0]     phase_o,
    output logic                load_o,
    output logic                clear_o,
    output logic                judge_o
);
    state_e             state_q, state_d;
    logic [LEN_W-1:0]   cnt_q;
    logic [LEN_W-1:0]   len_q;
    logic               in_phase;
    logic               last;
    logic               accept;

    assign in_phase = (state_q == ST_QUIET) || (state_q == ST_GOOD) ||
                      (state_q == ST_BAD)   || (state_q == ST_LIVE);
    assign last     = in_phase && (cnt_q == len_q - LEN_W'(1));
    assign accept   = (state_q == ST_IDLE) && start_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_QUIET;
            ST_QUIET: if (last)    state_d = ST_GOOD;
            ST_GOOD:  if (last)    state_d = ST_BAD;
            ST_BAD:   if (last)    state_d = ST_LIVE;
            ST_LIVE:  if (last)    state_d = ST_JUDGE;
            ST_JUDGE:              state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            len_q   <= LEN_W'(1);
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= '0;
                len_q <= (len_i == '0) ? LEN_W'(1) : len_i;
            end else if (last) begin
                cnt_q <= '0;
            end else if (in_phase) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end

    always_comb begin
        phase_o = '0;
        unique case (state_q)
            ST_QUIET: phase_o = PH_W'(0);
            ST_GOOD:  phase_o = PH_W'(1);
            ST_BAD:   phase_o = PH_W'(2);
            ST_LIVE:  phase_o = PH_W'(3);
            default:  phase_o = '0;
        endcase
        load_o  = last;
        clear_o = accept;
        judge_o = (state_q == ST_JUDGE);
    end

    // R1: fixed phase order
    a_r1_quiet_to_good: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUIET && last) |=> state_q == ST_GOOD);
    a_r1_bad_to_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BAD && last) |=> state_q == ST_LIVE);
    a_r1_live_to_judge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LIVE && last) |=> state_q == ST_JUDGE);
    // R2: no phase change before its last cycle
    a_r2_hold_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (in_phase && !last) |=> $stable(state_q));
    // R9: start while busy never restarts the sequence
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q != ST_IDLE) |=> !(state_q == ST_QUIET && cnt_q == '0));
endmodule

// File: rtl/bsc_capture.sv
module bsc_capture
    import bsc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                load_i,
    input  logic [PH_W-1:0]     slot_i,
    input  logic                fail_i,
    input  logic                err_i,
    output logic [VEC_W-1:0]    vec_o
);
    sym_e sym_now;
    sym_e slot_q [NPH];

    always_comb begin
        if (err_i)       sym_now = SYM_ERR;
        else if (fail_i) sym_now = SYM_FAIL;
        else             sym_now = SYM_PASS;
    end

    for (genvar k = 0; k < NPH; k++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[k] <= SYM_PASS;
            else if (clear_i)
                slot_q[k] <= SYM_PASS;
            else if (load_i && slot_i == PH_W'(k))
                slot_q[k] <= sym_now;
        end
        assign vec_o[k*SYM_W +: SYM_W] = slot_q[k];

        // R3: error flag has priority over fault flag
        a_r3_err_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (load_i && !clear_i && err_i && slot_i == PH_W'(k)) |=> slot_q[k] == SYM_ERR);
        // R3: lone fault flag gives the fault code
        a_r3_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
            (load_i && !clear_i && fail_i && !err_i && slot_i == PH_W'(k)) |=> slot_q[k] == SYM_FAIL);
    end
endmodule

// File: rtl/bsc_judge.sv
module bsc_judge
    import bsc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                judge_i,
    input  logic [VEC_W-1:0]    vec_i,
    output logic [CLS_W-1:0]    class_o,
    output logic                done_o
);
    class_e cls_d;
    class_e class_q;
    logic   done_q;

    always_comb begin
        if (vec_i == pack4(SYM_PASS, SYM_PASS, SYM_FAIL, SYM_PASS))
            cls_d = CL_ALL_OK;
        else if (vec_i == pack4(SYM_PASS, SYM_PASS, SYM_FAIL, SYM_FAIL))
            cls_d = CL_SYS_FAULT;
        else if (vec_i == pack4(SYM_PASS, SYM_PASS, SYM_PASS, SYM_PASS) ||
                 vec_i == pack4(SYM_ERR,  SYM_ERR,  SYM_ERR,  SYM_ERR)  ||
                 vec_i == pack4(SYM_PASS, SYM_FAIL, SYM_FAIL, SYM_FAIL))
            cls_d = CL_BIT_FAIL;
        else if (vec_i == pack4(SYM_PASS, SYM_ERR, SYM_ERR, SYM_ERR))
            cls_d = CL_AMBIG;
        else if (vec_i == pack4(SYM_PASS, SYM_PASS, SYM_PASS, SYM_FAIL))
            cls_d = CL_IMPOSS;
        else
            cls_d = CL_UNKNOWN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            class_q <= CL_NONE;
            done_q  <= 1'b0;
        end else if (clear_i) begin
            class_q <= CL_NONE;
            done_q  <= 1'b0;
        end else if (judge_i) begin
            class_q <= cls_d;
            done_q  <= 1'b1;
        end else begin
            done_q  <= 1'b0;
        end
    end

    assign class_o = class_q;
    assign done_o  = done_q;

    // R8: done never lasts two cycles
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R10: verdict changes only on start or judgement
    a_r10_class_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !judge_i) |=> $stable(class_q));
    // R4: healthy pattern gives verdict 1
    a_r4_all_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (judge_i && vec_i == pack4(SYM_PASS, SYM_PASS, SYM_FAIL, SYM_PASS)) |=> class_q == CL_ALL_OK);
    // R6: impossible pattern gives verdict 5
    a_r6_impossible: assert property (@(posedge clk) disable iff (!rst_n)
        (judge_i && vec_i == pack4(SYM_PASS, SYM_PASS, SYM_PASS, SYM_FAIL)) |=> class_q == CL_IMPOSS);
endmodule

// File: rtl/bit_selfcheck.sv
module bit_selfcheck
    import bsc_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [LEN_W-1:0]    phase_len_i,
    input  logic                cmp_fail_i,
    input  logic                cmp_err_i,
    output logic [PH_W-1:0]     stim_sel_o,
    output logic [VEC_W-1:0]    result_vec_o,
    output logic [CLS_W-1:0]    verdict_o,
    output logic                done_o
);
    logic [PH_W-1:0] phase;
    logic            load;
    logic            clear;
    logic            judge;

    bsc_phase_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .len_i   (phase_len_i),
        .phase_o (phase),
        .load_o  (load),
        .clear_o (clear),
        .judge_o (judge)
    );

    bsc_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .load_i  (load),
        .slot_i  (phase),
        .fail_i  (cmp_fail_i),
        .err_i   (cmp_err_i),
        .vec_o   (result_vec_o)
    );

    bsc_judge u_judge (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .judge_i (judge),
        .vec_i   (result_vec_o),
        .class_o (verdict_o),
        .done_o  (done_o)
    );

    assign stim_sel_o = phase;

    // R1: no stimulus while the verdict is being reported
    a_r1_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> stim_sel_o == '0);
endmodule

// File: tb/sim_bit_selfcheck.sv
module sim_bit_selfcheck;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] phase_len_i = '0;
    logic [1:0]       stim_sel_o;
    logic [7:0]       result_vec_o;
    logic [2:0]       verdict_o;
    logic             done_o;
    logic [1:0]       resp [4];
    logic             cmp_fail_i;
    logic             cmp_err_i;

    int total = 0;
    int bad   = 0;
    int dones = 0;
    logic prev_done = 1'b0;

    typedef struct {
        logic [7:0] vec;
        logic [2:0] cls;
        string      req;
    } exp_t;
    exp_t sb [$];

    always #2.5 clk = ~clk;

    // comparator model: response per stimulus (bit0 fault, bit1 error)
    assign cmp_fail_i = resp[stim_sel_o][0];
    assign cmp_err_i  = resp[stim_sel_o][1];

    bit_selfcheck #(.LEN_W(LEN_W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .phase_len_i  (phase_len_i),
        .cmp_fail_i   (cmp_fail_i),
        .cmp_err_i    (cmp_err_i),
        .stim_sel_o   (stim_sel_o),
        .result_vec_o (result_vec_o),
        .verdict_o    (verdict_o),
        .done_o       (done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // symbol from a response code: error wins (R3)
    function automatic logic [1:0] sym_of(input logic [1:0] r);
        if (r[1])      return 2'b10;
        else if (r[0]) return 2'b01;
        else           return 2'b00;
    endfunction

    // expected verdict per R4..R7, symbols in phase order
    function automatic logic [2:0] cls_of(input logic [1:0] s0, input logic [1:0] s1,
                                          input logic [1:0] s2, input logic [1:0] s3);
        logic [7:0] k;
        k = {s3, s2, s1, s0};
        case (k)
            8'b00_01_00_00: return 3'd1;
            8'b01_01_00_00: return 3'd2;
            8'b00_00_00_00,
            8'b10_10_10_10,
            8'b01_01_01_00: return 3'd3;
            8'b10_10_10_00: return 3'd4;
            8'b01_00_00_00: return 3'd5;
            default:        return 3'd6;
        endcase
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && prev_done)
                check(1'b0, "R8", "done longer than one cycle", 1, 0);
            if (done_o) begin
                dones++;
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "done with nothing expected", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result_vec_o == e.vec, "R3", "result vector",
                          int'(result_vec_o), int'(e.vec));
                    check(verdict_o == e.cls, e.req, "verdict",
                          int'(verdict_o), int'(e.cls));
                end
            end
            prev_done = done_o;
        end
    end

    // driver: one self-check cycle
    task automatic run(input logic [1:0] r0, input logic [1:0] r1,
                       input logic [1:0] r2, input logic [1:0] r3,
                       input int len, input string req, input int mid);
        int le;
        int n;
        int stim_bad;
        exp_t e;
        le = (len == 0) ? 1 : len;
        resp[0] = r0; resp[1] = r1; resp[2] = r2; resp[3] = r3;
        phase_len_i = LEN_W'(len);
        e.vec = {sym_of(r3), sym_of(r2), sym_of(r1), sym_of(r0)};
        e.cls = cls_of(sym_of(r0), sym_of(r1), sym_of(r2), sym_of(r3));
        e.req = req;
        sb.push_back(e);
        start_i = 1'b1;
        n = 0;
        stim_bad = 0;
        forever begin
            @(negedge clk);
            n++;
            start_i = (mid != 0 && n == mid) ? 1'b1 : 1'b0;
            if (n == 1) begin
                // R10: start clears vector and verdict
                check(result_vec_o == 8'h00, "R10", "vector cleared on start",
                      int'(result_vec_o), 0);
                check(verdict_o == 3'd0, "R10", "verdict cleared on start",
                      int'(verdict_o), 0);
            end
            if (n <= 4*le && stim_sel_o != 2'((n-1)/le) && stim_bad == 0) begin
                stim_bad = 1;
                check(1'b0, "R1", "stimulus select", int'(stim_sel_o), (n-1)/le);
            end
            if (done_o || n > 4*le + 20) break;
        end
        start_i = 1'b0;
        check(stim_bad == 0, "R1", "stimulus sequence", stim_bad, 0);
        check(n == 4*le + 2, "R8", "cycles to done", n, 4*le + 2);
        repeat (3) @(negedge clk);
        check(result_vec_o == e.vec, "R10", "vector held after done",
              int'(result_vec_o), int'(e.vec));
        check(verdict_o == e.cls, "R10", "verdict held after done",
              int'(verdict_o), int'(e.cls));
        check(stim_sel_o == 2'd0, "R1", "no stimulus when idle", int'(stim_sel_o), 0);
    endtask

    initial begin
        resp[0] = 2'd0; resp[1] = 2'd0; resp[2] = 2'd0; resp[3] = 2'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(stim_sel_o == 2'd0, "R11", "reset stim_sel", int'(stim_sel_o), 0);
        check(result_vec_o == 8'h00, "R11", "reset vector", int'(result_vec_o), 0);
        check(verdict_o == 3'd0, "R11", "reset verdict", int'(verdict_o), 0);
        check(done_o == 1'b0, "R11", "reset done", int'(done_o), 0);

        run(2'd0, 2'd0, 2'd1, 2'd0, 3, "R4", 0);   // healthy / healthy
        run(2'd0, 2'd0, 2'd1, 2'd1, 1, "R4", 0);   // system fault
        run(2'd0, 2'd0, 2'd0, 2'd0, 2, "R5", 0);   // all pass: test path stuck
        run(2'd2, 2'd2, 2'd2, 2'd2, 4, "R5", 0);   // all error
        run(2'd0, 2'd1, 2'd1, 2'd1, 2, "R5", 3);   // stuck fault, R9 mid-run start
        run(2'd0, 2'd2, 2'd2, 2'd2, 3, "R6", 0);   // ambiguous
        run(2'd0, 2'd0, 2'd0, 2'd1, 0, "R6", 0);   // impossible, R2 length 0
        run(2'd2, 2'd0, 2'd1, 2'd0, 2, "R7", 0);   // unlisted pattern
        run(2'd0, 2'd0, 2'd1, 2'd3, 1, "R7", 0);   // R3 error beats fault
        run(2'd0, 2'd0, 2'd1, 2'd0, 5, "R4", 17);  // R9 late mid-run start

        repeat (5) @(negedge clk);
        check(dones == 10, "R9", "done pulse count", dones, 10);
        check(sb.size() == 0, "R8", "unserved expectations", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule